// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the transaction layer of an SMBus target. A bit-level front end, not part of this block, turns the wire activity into single-cycle events: START (which also covers a repeated START), STOP, a received byte, and the host's ACK or NACK after each byte the target has sent. The responder turns those events into acknowledge decisions and outgoing data bytes. Behind it sits a small internal file of byte registers.

The first byte after an address+write is the command. It selects a register, and the block remembers it as the pointer. Further bytes in the same write land in that register and then in the ones after it. A word write is therefore two bytes in a row: the low byte first, then the high byte.

A read phase starts from the pointer. It can follow a repeated START after the command, or come with no command at all, which is a Receive Byte. The read walks upward through the registers for as long as the host keeps acknowledging. One command code is reserved for a block read, which sends a count byte and then every register in turn. The pointer is kept across STOP.

Top module: `smbt_target`

## Requirements
- R1: The address byte is the first byte after START. Bits [7:1] hold the address and bit 0 holds the direction (1 = read). That byte is ACKed only when bits [7:1] equal OWN_ADDR. After any other address, every byte is NACKed and data is never driven until the next START.
- R2: After an address+write, the first byte is the command. It is ACKed when it is below NUM_REGS or equal to BLK_CMD. Any other command is NACKed, leaves the pointer unchanged, and every byte after it is NACKed until the next START.
- R3: Data bytes that follow an accepted command are ACKed and stored in register cmd, then cmd+1, and so on, so a word write stores the low byte first. A byte that would go past the last register is NACKed and not stored, and so is any data byte sent after BLK_CMD.
- R4: A command followed by a repeated START and address+read sends that register's contents. Each host ACK advances to the next register (low byte, then high byte), and tx_byte_o holds steady while no response arrives.
- R5: A read that has no command before it starts at the register selected by the most recently accepted command.
- R6: A read after command BLK_CMD sends the count NUM_REGS first, then registers 0 to NUM_REGS-1 in order.
- R7: A host NACK on a sent byte drops tx_en_o in the next cycle.
- R8: STOP ends the transaction: tx_en_o falls, and bytes received before the next START are NACKed. The pointer is kept.
- R9: After reset, all registers and the pointer are 0, tx_en_o is 0 and ack_vld_o is 0.
- R10: A read of an index at or past NUM_REGS sends 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | START or repeated START event |
| stop_i | input | 1 | STOP event |
| rx_vld_i | input | 1 | A byte has been received from the host |
| rx_byte_i | input | 8 | Received byte |
| tx_done_i | input | 1 | The host has answered a byte sent by the target |
| host_ack_i | input | 1 | That answer: 1 = ACK, 0 = NACK |
| ack_vld_o | output | 1 | ack_o is valid (one cycle after rx_vld_i) |
| ack_o | output | 1 | 1 = ACK the received byte |
| tx_en_o | output | 1 | Target drives data (read phase) |
| tx_byte_o | output | 8 | Byte to send |

## Verification
The register path is driven with single-byte writes, word writes, writes that run past the last register, and writes to the block code. Reading these back shows whether the pointer increments on its own and where the write boundary lies. Reads come in three forms: a combined command and repeated START read, a Receive Byte with no command, and the same Receive Byte issued after a STOP. Comparing them tells a pointer that is kept from one that is reset or advanced. Foreign addresses, invalid commands and a STOP in the middle of a read check that the phase tracking drops out to idle. A full block read confirms the count prefix and the order of the registers.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_CMD, PH_WDATA, PH_RDATA
  } phase_e;
endpackage

// File: rtl/smbt_reg_file.sv
module smbt_reg_file
  import smbt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  byte_t wr_idx_i,
  input  byte_t wr_data_i,
  input  byte_t rd_idx_i,
  output byte_t rd_data_o
);
  byte_t regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[g] <= '0;
      else if (wr_en_i && (wr_idx_i == byte_t'(g))) regs_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_idx_i == byte_t'(i)) rd_data_o = regs_q[i];
  end
endmodule

// File: rtl/smbt_phase_ctrl.sv
module smbt_phase_ctrl
  import smbt_pkg::*;
#(
  parameter logic [6:0]  OWN_ADDR = 7'h3A,
  parameter int unsigned NUM_REGS = 8,
  parameter byte_t       BLK_CMD  = 8'h80
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   stop_i,
  input  logic   rx_vld_i,
  input  byte_t  rx_byte_i,
  input  logic   tx_done_i,
  input  logic   host_ack_i,
  output logic   ack_vld_o,
  output logic   ack_o,
  output logic   wr_en_o,
  output byte_t  idx_o,
  output logic   blk_hdr_o,
  output phase_e phase_o
);
  phase_e phase_q;
  byte_t  ptr_q, idx_q;
  logic   blk_hdr_q;
  logic   rx_ok, addr_hit, cmd_ok, wr_ok, ack_now;

  assign rx_ok    = rx_vld_i && !start_i && !stop_i;
  assign addr_hit = (rx_byte_i[7:1] == OWN_ADDR);
  assign cmd_ok   = (rx_byte_i < byte_t'(NUM_REGS)) || (rx_byte_i == BLK_CMD);
  assign wr_ok    = (ptr_q != BLK_CMD) && (idx_q < byte_t'(NUM_REGS));

  always_comb begin
    unique case (phase_q)
      PH_ADDR:  ack_now = addr_hit;
      PH_CMD:   ack_now = cmd_ok;
      PH_WDATA: ack_now = wr_ok;
      default:  ack_now = 1'b0;
    endcase
  end

  assign wr_en_o = rx_ok && (phase_q == PH_WDATA) && wr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      ptr_q     <= '0;
      idx_q     <= '0;
      blk_hdr_q <= 1'b0;
      ack_vld_o <= 1'b0;
      ack_o     <= 1'b0;
    end else begin
      ack_vld_o <= rx_vld_i;
      ack_o     <= rx_ok && ack_now;
      if (start_i) begin
        phase_q   <= PH_ADDR;
        blk_hdr_q <= 1'b0;
      end else if (stop_i) begin
        phase_q   <= PH_IDLE;
        blk_hdr_q <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_ADDR: if (rx_vld_i) begin
            if (!addr_hit)         phase_q <= PH_IDLE;
            else if (rx_byte_i[0]) begin
              phase_q   <= PH_RDATA;
              blk_hdr_q <= (ptr_q == BLK_CMD);
              idx_q     <= (ptr_q == BLK_CMD) ? '0 : ptr_q;
            end else               phase_q <= PH_CMD;
          end
          PH_CMD: if (rx_vld_i) begin
            if (cmd_ok) begin
              ptr_q   <= rx_byte_i;
              idx_q   <= rx_byte_i;
              phase_q <= PH_WDATA;
            end else phase_q <= PH_IDLE;
          end
          PH_WDATA: if (rx_vld_i) begin
            if (!wr_ok) phase_q <= PH_IDLE;
            else        idx_q   <= idx_q + 8'd1;
          end
          PH_RDATA: if (tx_done_i) begin
            if (!host_ack_i)           phase_q   <= PH_IDLE;
            else if (blk_hdr_q)        blk_hdr_q <= 1'b0;
            else if (idx_q != 8'hFF)   idx_q     <= idx_q + 8'd1;
          end
          default: ;
        endcase
      end
    end
  end

  assign idx_o     = idx_q;
  assign blk_hdr_o = blk_hdr_q;
  assign phase_o   = phase_q;
endmodule

// File: rtl/smbt_tx_sel.sv
module smbt_tx_sel
  import smbt_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8
) (
  input  phase_e phase_i,
  input  logic   blk_hdr_i,
  input  byte_t  rd_data_i,
  output logic   tx_en_o,
  output byte_t  tx_byte_o
);
  localparam byte_t BLK_COUNT = byte_t'(NUM_REGS);
  assign tx_en_o   = (phase_i == PH_RDATA);
  assign tx_byte_o = blk_hdr_i ? BLK_COUNT : rd_data_i;
endmodule

// File: rtl/smbt_target.sv
module smbt_target
  import smbt_pkg::*;
#(
  parameter logic [6:0]  OWN_ADDR = 7'h3A,
  parameter int unsigned NUM_REGS = 8,
  parameter logic [7:0]  BLK_CMD  = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       rx_vld_i,
  input  logic [7:0] rx_byte_i,
  input  logic       tx_done_i,
  input  logic       host_ack_i,
  output logic       ack_vld_o,
  output logic       ack_o,
  output logic       tx_en_o,
  output logic [7:0] tx_byte_o
);
  logic   wr_en, blk_hdr;
  byte_t  idx, rd_data;
  phase_e phase;

  smbt_phase_ctrl #(.OWN_ADDR(OWN_ADDR), .NUM_REGS(NUM_REGS), .BLK_CMD(BLK_CMD)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .rx_vld_i, .rx_byte_i, .tx_done_i, .host_ack_i,
    .ack_vld_o, .ack_o, .wr_en_o(wr_en), .idx_o(idx), .blk_hdr_o(blk_hdr), .phase_o(phase)
  );

  smbt_reg_file #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(idx), .wr_data_i(rx_byte_i),
    .rd_idx_i(idx), .rd_data_o(rd_data)
  );

  smbt_tx_sel #(.NUM_REGS(NUM_REGS)) u_tx (
    .phase_i(phase), .blk_hdr_i(blk_hdr), .rd_data_i(rd_data),
    .tx_en_o, .tx_byte_o
  );
endmodule

// File: rtl/smbt_checker.sv
module smbt_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       stop_i,
  input logic       tx_done_i,
  input logic       host_ack_i,
  input logic       ack_vld_o,
  input logic       ack_o,
  input logic       tx_en_o,
  input logic [7:0] tx_byte_o
);
  AST_ACK_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> ack_vld_o); // R1

  AST_NACK_ENDS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && tx_done_i && !host_ack_i && !start_i) |=> !tx_en_o); // R7

  AST_STOP_ENDS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !tx_en_o); // R8

  AST_START_ENDS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !tx_en_o); // R1

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && !tx_done_i && !start_i && !stop_i) |=> (tx_en_o && $stable(tx_byte_o))); // R4
endmodule

bind smbt_target smbt_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .tx_done_i(tx_done_i), .host_ack_i(host_ack_i), .ack_vld_o(ack_vld_o),
  .ack_o(ack_o), .tx_en_o(tx_en_o), .tx_byte_o(tx_byte_o)
);

// File: tb/sim_smbt_target.sv
`timescale 1ns/1ps
module sim_smbt_target;
  localparam logic [7:0] A_WR = 8'h74;  // address 7'h3A, write
  localparam logic [7:0] A_RD = 8'h75;  // address 7'h3A, read

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, stop = 0, rx_vld = 0, tx_done = 0, host_ack = 0;
  logic [7:0] rx_byte = '0;
  logic ack_vld, ack, tx_en;
  logic [7:0] tx_byte;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  smbt_target u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .rx_vld_i(rx_vld),
    .rx_byte_i(rx_byte), .tx_done_i(tx_done), .host_ack_i(host_ack),
    .ack_vld_o(ack_vld), .ack_o(ack), .tx_en_o(tx_en), .tx_byte_o(tx_byte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic ev_start();
    @(negedge clk) start = 1; @(negedge clk) start = 0;
  endtask
  task automatic ev_stop();
    @(negedge clk) stop = 1; @(negedge clk) stop = 0;
  endtask
  task automatic wr(input logic [7:0] b, output logic a);
    @(negedge clk) begin rx_vld = 1; rx_byte = b; end
    @(negedge clk) rx_vld = 0;
    a = ack_vld & ack;
  endtask
  task automatic rd(input logic hack, output logic [7:0] b);
    @(negedge clk) begin b = tx_byte; tx_done = 1; host_ack = hack; end
    @(negedge clk) tx_done = 0;
  endtask
  task automatic wr_exp(input string req, input logic [7:0] b, input logic e);
    logic a;
    wr(b, a);
    check(req, {7'd0, a}, {7'd0, e});
  endtask

  task automatic t_reset();
    logic [7:0] b;
    check("R9 tx_en", {7'd0, tx_en}, 8'd0);
    check("R9 ack_vld", {7'd0, ack_vld}, 8'd0);
    ev_start(); wr_exp("R9 addr", A_RD, 1'b1);
    rd(1'b0, b); check("R9 reg0 via ptr0", b, 8'h00);
    ev_stop();
  endtask

  task automatic t_foreign_addr();
    ev_start(); wr_exp("R1 foreign addr", 8'h20, 1'b0);
    wr_exp("R1 later byte", 8'h05, 1'b0);
    check("R1 no drive", {7'd0, tx_en}, 8'd0);
    ev_stop();
  endtask

  task automatic t_byte_rw();
    logic [7:0] b;
    ev_start(); wr_exp("R1 own addr", A_WR, 1'b1);
    wr_exp("R2 cmd 3", 8'h03, 1'b1); wr_exp("R3 data", 8'hA5, 1'b1);
    ev_stop();
    ev_start(); wr_exp("R4 addr", A_WR, 1'b1); wr_exp("R4 cmd", 8'h03, 1'b1);
    ev_start(); wr_exp("R4 rs addr", A_RD, 1'b1);
    check("R4 tx_en", {7'd0, tx_en}, 8'd1);
    repeat (3) @(negedge clk);
    check("R4 hold", tx_byte, 8'hA5);
    rd(1'b0, b); check("R4 byte read", b, 8'hA5);
    check("R7 nack drop", {7'd0, tx_en}, 8'd0);
    ev_stop();
  endtask

  task automatic t_word();
    logic [7:0] b;
    ev_start(); wr_exp("R3 addr", A_WR, 1'b1); wr_exp("R3 cmd 5", 8'h05, 1'b1);
    wr_exp("R3 low", 8'h34, 1'b1); wr_exp("R3 high", 8'h12, 1'b1);
    ev_stop();
    ev_start(); wr_exp("R4 addr", A_WR, 1'b1); wr_exp("R4 cmd", 8'h05, 1'b1);
    ev_start(); wr_exp("R4 rs", A_RD, 1'b1);
    rd(1'b1, b); check("R4 word low", b, 8'h34);
    rd(1'b0, b); check("R4 word high", b, 8'h12);
    check("R7 after high", {7'd0, tx_en}, 8'd0);
    ev_stop();
  endtask

  task automatic t_bad_cmd();
    logic [7:0] b;
    ev_start(); wr_exp("R2 addr", A_WR, 1'b1);
    wr_exp("R2 bad cmd", 8'h40, 1'b0); wr_exp("R2 data after bad", 8'h99, 1'b0);
    ev_start(); wr_exp("R5 addr", A_RD, 1'b1);
    rd(1'b0, b); check("R5 ptr unchanged", b, 8'h34);
    ev_stop();
    ev_start(); wr_exp("R8 addr", A_RD, 1'b1);
    rd(1'b0, b); check("R8 ptr kept over stop", b, 8'h34);
    ev_stop();
  endtask

  task automatic t_overflow();
    logic [7:0] b;
    ev_start(); wr_exp("R3 addr", A_WR, 1'b1); wr_exp("R3 cmd 7", 8'h07, 1'b1);
    wr_exp("R3 last reg", 8'h77, 1'b1); wr_exp("R3 past end", 8'h88, 1'b0);
    ev_start(); wr_exp("R10 addr", A_RD, 1'b1);
    rd(1'b1, b); check("R10 reg7", b, 8'h77);
    rd(1'b0, b); check("R10 past end", b, 8'hFF);
    ev_stop();
  endtask

  task automatic t_block();
    logic [7:0] b;
    logic [7:0] exp [8] = '{8'h00, 8'h00, 8'h00, 8'hA5, 8'h00, 8'h34, 8'h12, 8'h77};
    ev_start(); wr_exp("R6 addr", A_WR, 1'b1); wr_exp("R6 cmd", 8'h80, 1'b1);
    wr_exp("R3 blk data", 8'h55, 1'b0);
    ev_start(); wr_exp("R6 rs", A_RD, 1'b1);
    rd(1'b1, b); check("R6 count", b, 8'd8);
    for (int i = 0; i < 8; i++) begin
      rd(i != 7, b); check($sformatf("R6 data %0d", i), b, exp[i]);
    end
    check("R7 blk end", {7'd0, tx_en}, 8'd0);
    ev_stop();
  endtask

  task automatic t_stop_mid();
    ev_start(); wr_exp("R8 addr", A_RD, 1'b1);
    check("R8 driving", {7'd0, tx_en}, 8'd1);
    ev_stop();
    check("R8 stop drop", {7'd0, tx_en}, 8'd0);
    wr_exp("R8 byte after stop", A_WR, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_foreign_addr();
    t_byte_rw();
    t_word();
    t_bad_cmd();
    t_overflow();
    t_block();
    t_stop_mid();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule